// File: doc/BRIEF.md
# Breakpoint Clock-Stop Controller

This block freezes a chip's functional clock at a programmed moment so that its complete register state can be dumped through the scan chains already present for manufacturing test. A debugger programs a trigger over a test-clock register interface and then resets and runs the chip. The trigger is either one masked comparison against an observed event vector, or a chain of such comparisons that must match on consecutive delivered cycles. When the trigger fires, the gated functional clock stops and a cycle stamp freezes. The halt becomes visible on the test-clock side.

The debugger then requests scan mode. The block hands its clock output to the test clock and raises scan enable, so the existing chains shift out the frozen state. No extra capture storage is involved. A resume command leaves scan mode, clears the halt and returns the functional clock. Each clock handover is glitch-free: one source is gated off, a two-flop synchronizer in the other domain observes this, and only then is the other source gated on.

Top module: `bpClockStop`

## Requirements
- R1: The trigger settings are a 131-bit word. It is shifted in least significant bit first on rising test-clock edges while shift enable is high, and it becomes active on a rising test-clock edge with update high. Bit 0 is the enable. Bits 2:1 hold the index of the final stage. Stage k occupies bits 3+32k upward: the low 16 bits are the compare value and the high 16 bits are the mask, where a 1 means the bit is compared.
- R2: With final-stage index 0, the halt takes effect on the first delivered functional cycle whose masked event vector equals stage 0.
- R3: A sequence advances one stage on each delivered cycle that matches the current stage, and it fires when the final stage matches. On a mismatch it returns to stage 0, or to stage 1 if that same vector matches stage 0.
- R4: Once the trigger fires, no further functional clock pulses appear on the gated clock.
- R5: The halt is reported on the haltSeen output within three test-clock cycles.
- R6: A scan request takes effect only while haltSeen is high. When it takes effect, scanEnable rises within four test-clock cycles.
- R7: In scan mode the gated clock follows the test clock, with one pulse per test-clock cycle.
- R8: A functional reset clears the matcher, the halt and the cycle counter, but leaves the trigger settings unchanged.
- R9: The cycle counter counts delivered functional pulses since the functional reset, including the firing pulse, and holds its value while halted.
- R10: A resume request while haltSeen is high lowers scanEnable at the next test-clock edge and clears the halt. Functional pulses return only after the test-clock pulses have stopped.
- R11: With the enable bit cleared, no event pattern ever halts the clock.
- R12: While the clock-enable input is low, no functional pulses are delivered, and the matcher and the counter hold their state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| funcClk | input | 1 | Free-running functional source clock |
| funcRstN | input | 1 | Functional reset, active low, asynchronous |
| clkEnIn | input | 1 | Functional clock enable |
| eventVec | input | 16 | Observed event vector, sampled on delivered cycles |
| tck | input | 1 | Test clock |
| trstN | input | 1 | Test-side reset, active low; clears the settings |
| cfgShiftEn | input | 1 | Shift the settings register by one bit |
| cfgTdi | input | 1 | Serial settings data in |
| cfgUpdate | input | 1 | Copy the shifted word into the active settings |
| scanReq | input | 1 | Request scan mode (test-clock domain) |
| resumeReq | input | 1 | Resume command (test-clock domain) |
| haltSeen | output | 1 | Halt flag, synchronized to the test clock |
| cycleCount | output | 32 | Delivered functional cycle stamp |
| scanEnable | output | 1 | Scan shift enable for the reused chains |
| gatedClk | output | 1 | Clock delivered to the functional logic |

## Verification
A stage pointer that is wrong shows up at the ports as a halt that comes too early, too late or never. The cycle stamp then differs from the count of delivered pulses, and this is visible within one functional cycle of the final event. A faulty handover, or a halt flag that does not release, shows up as extra or missing pulses on the gated clock. It also leaves haltSeen or scanEnable stuck, and the bench detects this within a few test-clock cycles of the request or resume. Settings lost to a functional reset appear when the same event stream is replayed and fails to fire at the same stamp.

// File: rtl/bpPkg.sv
package bpPkg;
  // strobes from the control half to the datapath half
  typedef struct packed {
    logic cntInc;   // a functional pulse is being delivered this cycle
  } bpStrobeT;
endpackage

// File: rtl/bpData.sv
module bpData
  import bpPkg::*;
#(
  parameter int EVW  = 16,
  parameter int NSTG = 4,
  parameter int CNTW = 32,
  localparam int STGW = (NSTG > 1) ? $clog2(NSTG) : 1,
  localparam int CFGW = 1 + STGW + 2 * EVW * NSTG
)(
  input  logic            tck,
  input  logic            trstN,
  input  logic            cfgShiftEn,
  input  logic            cfgTdi,
  input  logic            cfgUpdate,
  input  logic            funcClk,
  input  logic            funcRstN,
  input  logic [EVW-1:0]  eventVec,
  input  bpStrobeT        strobe,
  output logic [NSTG-1:0] hitVec,
  output logic            cfgEn,
  output logic [STGW-1:0] lastStg,
  output logic [CNTW-1:0] cycleCount
);

  logic [CFGW-1:0] shiftReg;
  logic [CFGW-1:0] cfgShadow;

  // settings live on the test side only; a functional reset never touches them
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      shiftReg  <= '0;
      cfgShadow <= '0;
    end else begin
      if (cfgShiftEn) shiftReg <= {cfgTdi, shiftReg[CFGW-1:1]};
      if (cfgUpdate)  cfgShadow <= shiftReg;
    end
  end

  assign cfgEn   = cfgShadow[0];
  assign lastStg = cfgShadow[STGW:1];

  for (genvar g = 0; g < NSTG; g++) begin : gStage
    localparam int BASE = 1 + STGW + 2 * EVW * g;
    logic [EVW-1:0] val;
    logic [EVW-1:0] msk;
    assign val       = cfgShadow[BASE +: EVW];
    assign msk       = cfgShadow[BASE + EVW +: EVW];
    assign hitVec[g] = ((eventVec ^ val) & msk) == '0;
  end

  always_ff @(posedge funcClk or negedge funcRstN) begin
    if (!funcRstN)          cycleCount <= '0;
    else if (strobe.cntInc) cycleCount <= cycleCount + CNTW'(1);
  end

  // R8: active settings change only on an update
  p_cfg_hold_r8: assert property (@(posedge tck) disable iff (!trstN)
    !cfgUpdate |=> $stable(cfgShadow));

  // R9: stamp moves only on a delivered pulse
  p_count_hold_r9: assert property (@(posedge funcClk) disable iff (!funcRstN)
    !strobe.cntInc |=> $stable(cycleCount));

endmodule

// File: rtl/bpCtrl.sv
module bpCtrl
  import bpPkg::*;
#(
  parameter int NSTG = 4,
  localparam int STGW = (NSTG > 1) ? $clog2(NSTG) : 1
)(
  input  logic            funcClk,
  input  logic            funcRstN,
  input  logic            clkEnIn,
  input  logic            tck,
  input  logic            trstN,
  input  logic            scanReq,
  input  logic            resumeReq,
  input  logic [NSTG-1:0] hitVec,
  input  logic            cfgEn,
  input  logic [STGW-1:0] lastStg,
  output bpStrobeT        strobe,
  output logic            haltSeen,
  output logic            scanEnable,
  output logic            gatedClk
);

  logic [STGW-1:0] stg, nxtStg;
  logic fire, halted, funcGate, scanMode, tckOn, resumeTog, resumeEdge;
  logic [1:0] funcSync, haltSync, tckSync;
  logic [2:0] resSync;

  // sequence matcher, evaluated only on delivered cycles
  always_comb begin
    fire   = 1'b0;
    nxtStg = stg;
    if (cfgEn && funcGate && !halted) begin
      if (hitVec[stg]) begin
        if (stg == lastStg) begin
          fire   = 1'b1;
          nxtStg = '0;
        end else begin
          nxtStg = stg + STGW'(1);
        end
      end else if (stg != '0 && hitVec[0]) begin
        nxtStg = STGW'(1);
      end else begin
        nxtStg = '0;
      end
    end
  end

  assign resumeEdge    = resSync[2] ^ resSync[1];
  assign strobe.cntInc = funcGate;

  always_ff @(posedge funcClk or negedge funcRstN) begin
    if (!funcRstN) begin
      stg    <= '0;
      halted <= 1'b0;
    end else begin
      stg <= nxtStg;
      if (fire)            halted <= 1'b1;
      else if (resumeEdge) halted <= 1'b0;
    end
  end

  // functional-side half of the clock handover
  always_ff @(posedge funcClk or negedge trstN) begin
    if (!trstN) begin
      resSync  <= '0;
      funcSync <= '0;
    end else begin
      resSync  <= {resSync[1:0], resumeTog};
      funcSync <= {funcSync[0], ~(scanMode | tckOn)};
    end
  end

  always_ff @(negedge funcClk or negedge trstN) begin
    if (!trstN) funcGate <= 1'b0;
    else        funcGate <= funcSync[1] & ~halted & clkEnIn;
  end

  // test-side status, commands and the other half of the handover
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      haltSync  <= '0;
      tckSync   <= '0;
      scanMode  <= 1'b0;
      resumeTog <= 1'b0;
    end else begin
      haltSync <= {haltSync[0], halted};
      tckSync  <= {tckSync[0], scanMode & ~funcGate};
      if (resumeReq && haltSeen) begin
        scanMode  <= 1'b0;
        resumeTog <= ~resumeTog;
      end else if (scanReq && haltSeen) begin
        scanMode <= 1'b1;
      end
    end
  end

  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN) tckOn <= 1'b0;
    else        tckOn <= tckSync[1];
  end

  assign haltSeen   = haltSync[1];
  assign scanEnable = scanMode & tckOn;
  assign gatedClk   = (funcClk & funcGate) | (tck & tckOn);

  // R2: single-stage hit on a delivered cycle halts at that edge
  p_single_fire_r2: assert property (@(posedge funcClk) disable iff (!funcRstN)
    (cfgEn && funcGate && !halted && lastStg == '0 && hitVec[0]) |=> halted);

  // R3: a halt is only ever entered from the final stage
  p_fire_from_last_r3: assert property (@(posedge funcClk) disable iff (!funcRstN)
    $rose(halted) |-> ($past(stg) == lastStg));

  // R4: a halted matcher sees no delivered pulse
  p_clock_stopped_r4: assert property (@(posedge funcClk) disable iff (!funcRstN)
    halted |-> !funcGate);

  // R6: scan shifting never runs without a reported halt
  p_scan_needs_halt_r6: assert property (@(posedge tck) disable iff (!trstN)
    scanEnable |-> haltSeen);

  // R10: the two clock sources are never gated on together
  p_clk_exclusive_r10: assert property (@(posedge funcClk) disable iff (!trstN)
    funcGate |-> !tckOn);

  // R11: a disabled trigger cannot raise the halt
  p_disabled_no_halt_r11: assert property (@(posedge funcClk) disable iff (!funcRstN)
    (!cfgEn && !halted) |=> !halted);

endmodule

// File: rtl/bpClockStop.sv
module bpClockStop
  import bpPkg::*;
#(
  parameter int EVW  = 16,
  parameter int NSTG = 4,
  parameter int CNTW = 32
)(
  input  logic            funcClk,
  input  logic            funcRstN,
  input  logic            clkEnIn,
  input  logic [EVW-1:0]  eventVec,
  input  logic            tck,
  input  logic            trstN,
  input  logic            cfgShiftEn,
  input  logic            cfgTdi,
  input  logic            cfgUpdate,
  input  logic            scanReq,
  input  logic            resumeReq,
  output logic            haltSeen,
  output logic [CNTW-1:0] cycleCount,
  output logic            scanEnable,
  output logic            gatedClk
);

  localparam int STGW = (NSTG > 1) ? $clog2(NSTG) : 1;

  bpStrobeT        strobe;
  logic [NSTG-1:0] hitVec;
  logic            cfgEn;
  logic [STGW-1:0] lastStg;

  bpData #(.EVW(EVW), .NSTG(NSTG), .CNTW(CNTW)) i_data (
    .tck(tck), .trstN(trstN), .cfgShiftEn(cfgShiftEn), .cfgTdi(cfgTdi),
    .cfgUpdate(cfgUpdate), .funcClk(funcClk), .funcRstN(funcRstN),
    .eventVec(eventVec), .strobe(strobe), .hitVec(hitVec), .cfgEn(cfgEn),
    .lastStg(lastStg), .cycleCount(cycleCount)
  );

  bpCtrl #(.NSTG(NSTG)) i_ctrl (
    .funcClk(funcClk), .funcRstN(funcRstN), .clkEnIn(clkEnIn), .tck(tck),
    .trstN(trstN), .scanReq(scanReq), .resumeReq(resumeReq), .hitVec(hitVec),
    .cfgEn(cfgEn), .lastStg(lastStg), .strobe(strobe), .haltSeen(haltSeen),
    .scanEnable(scanEnable), .gatedClk(gatedClk)
  );

endmodule

// File: tb/test_bpClockStop.sv
module test_bpClockStop;

  localparam int CFGW = 131;
  localparam int NROW = 7;

  typedef struct packed {
    logic            en;
    logic [1:0]      last;
    logic [2:0]      fireIdx;   // 7 means no halt expected
    logic [0:5][15:0] evt;
  } rowT;

  localparam rowT VEC [NROW] = '{
    '{1'b1, 2'd0, 3'd1, {16'h0000, 16'h1111, 16'h0000, 16'h0000, 16'h0000, 16'h0000}},
    '{1'b1, 2'd1, 3'd1, {16'h1111, 16'h2222, 16'h0000, 16'h0000, 16'h0000, 16'h0000}},
    '{1'b1, 2'd1, 3'd4, {16'h1111, 16'h0000, 16'h2222, 16'h1111, 16'hAB22, 16'h0000}},
    '{1'b1, 2'd3, 3'd3, {16'h1111, 16'h2222, 16'h3333, 16'h4444, 16'h0000, 16'h0000}},
    '{1'b1, 2'd3, 3'd5, {16'h1111, 16'h2222, 16'h1111, 16'h2222, 16'h3333, 16'h4444}},
    '{1'b0, 2'd0, 3'd7, {16'h1111, 16'h1111, 16'h1111, 16'h0000, 16'h0000, 16'h0000}},
    '{1'b1, 2'd2, 3'd3, {16'h1110, 16'h1111, 16'h2222, 16'h3333, 16'h0000, 16'h0000}}
  };

  logic funcClk = 1'b0, tck = 1'b0;
  logic funcRstN, trstN, clkEnIn, cfgShiftEn, cfgTdi, cfgUpdate, scanReq, resumeReq;
  logic [15:0] eventVec;
  logic haltSeen, scanEnable, gatedClk;
  logic [31:0] cycleCount;

  int nChecks = 0, nFail = 0;
  int cntDeliv = 0, pulseAll = 0;
  bit done = 0;

  always #2 funcClk = ~funcClk;   // 250 MHz
  always #5 tck = ~tck;

  bpClockStop i_bpClockStop (
    .funcClk(funcClk), .funcRstN(funcRstN), .clkEnIn(clkEnIn), .eventVec(eventVec),
    .tck(tck), .trstN(trstN), .cfgShiftEn(cfgShiftEn), .cfgTdi(cfgTdi),
    .cfgUpdate(cfgUpdate), .scanReq(scanReq), .resumeReq(resumeReq),
    .haltSeen(haltSeen), .cycleCount(cycleCount), .scanEnable(scanEnable),
    .gatedClk(gatedClk)
  );

  always @(posedge gatedClk or negedge funcRstN)
    if (!funcRstN) cntDeliv <= 0;
    else           cntDeliv <= cntDeliv + 1;

  always @(posedge gatedClk) pulseAll <= pulseAll + 1;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [CFGW-1:0] mkCfg(logic en, logic [1:0] last);
    logic [CFGW-1:0] c = '0;
    logic [15:0] vals [4] = '{16'h1111, 16'h2222, 16'h3333, 16'h4444};
    logic [15:0] msks [4] = '{16'hFFFF, 16'h00FF, 16'hFFFF, 16'hFFFF};
    c[0]   = en;
    c[2:1] = last;
    for (int k = 0; k < 4; k++) begin
      c[3 + 32*k +: 16]  = vals[k];
      c[19 + 32*k +: 16] = msks[k];
    end
    return c;
  endfunction

  task automatic shiftCfg(logic [CFGW-1:0] c);   // R1 loading
    for (int i = 0; i < CFGW; i++) begin
      @(negedge tck); cfgShiftEn = 1'b1; cfgTdi = c[i];
    end
    @(negedge tck); cfgShiftEn = 1'b0; cfgUpdate = 1'b1;
    @(negedge tck); cfgUpdate = 1'b0;
  endtask

  task automatic funcReset();
    @(negedge funcClk); funcRstN = 1'b0;
    repeat (3) @(negedge funcClk);
    funcRstN = 1'b1;
  endtask

  task automatic runEvents(logic [0:5][15:0] evt, int fireIdx, string tag);
    int base;
    funcReset();
    repeat (6) @(negedge funcClk);
    base = cntDeliv;
    for (int i = 0; i < 6; i++) begin
      eventVec = evt[i];
      @(negedge funcClk);
    end
    eventVec = '0;
    repeat (20) @(negedge funcClk);
    if (fireIdx < 6) chk({tag, " stamp"}, cycleCount, base + fireIdx + 1);
    else             chk({tag, " stamp"}, cycleCount, cntDeliv);
    @(negedge tck); #2;
    chk({tag, " haltSeen R5"}, {31'd0, haltSeen}, (fireIdx < 6) ? 32'd1 : 32'd0);
  endtask

  function automatic string rowTag(int r);
    case (r)
      0:       return "R2 row0";
      5:       return "R11 row5";
      default: return $sformatf("R3 row%0d", r);
    endcase
  endfunction

  initial begin
    funcRstN = 0; trstN = 0; clkEnIn = 1; eventVec = '0;
    cfgShiftEn = 0; cfgTdi = 0; cfgUpdate = 0; scanReq = 0; resumeReq = 0;
    #30;
    chk("reset scanEnable R6", {31'd0, scanEnable}, 0);
    chk("reset haltSeen R5", {31'd0, haltSeen}, 0);
    chk("reset stamp R9", cycleCount, 0);
    @(negedge tck); trstN = 1;

    // table walk: R1 settings, R2/R3 matching, R9 stamp, R11 disabled trigger
    for (int r = 0; r < NROW; r++) begin
      shiftCfg(mkCfg(VEC[r].en, VEC[r].last));
      runEvents(VEC[r].evt, (VEC[r].fireIdx == 3'd7) ? 99 : int'(VEC[r].fireIdx), rowTag(r));
    end

    // R8: functional reset keeps the last settings; same stream fires again
    runEvents(VEC[6].evt, 3, "R8 replay");

    // R4: halted, so no pulses at all
    begin
      int p0, c0;
      @(negedge funcClk); p0 = pulseAll; c0 = cycleCount;
      repeat (20) @(negedge funcClk);
      chk("R4 no pulses while halted", pulseAll, p0);

      // R6: scan request while halted
      @(negedge tck); scanReq = 1;
      @(negedge tck); scanReq = 0;
      repeat (6) @(negedge tck); #2;
      chk("R6 scanEnable on", {31'd0, scanEnable}, 1);

      // R7: one pulse per test clock
      p0 = pulseAll;
      repeat (10) @(negedge tck); #2;
      chk("R7 test-clock pulses", pulseAll - p0, 10);
      chk("R9 stamp frozen", cycleCount, c0);

      // R10: resume
      @(negedge tck); resumeReq = 1;
      @(negedge tck); resumeReq = 0; #2;
      chk("R10 scanEnable off", {31'd0, scanEnable}, 0);
      repeat (30) @(negedge funcClk);
      chk("R10 functional clock back", {31'd0, cycleCount > c0}, 1);
      @(negedge tck); #2;
      chk("R10 haltSeen cleared", {31'd0, haltSeen}, 0);

      // R6: scan request ignored when not halted
      @(negedge tck); scanReq = 1;
      @(negedge tck); scanReq = 0;
      repeat (6) @(negedge tck); #2;
      chk("R6 scan ignored", {31'd0, scanEnable}, 0);
    end

    // R12: clock enable low holds matcher and counter (settings: stages 1111,2222,3333)
    begin
      int base, p0;
      funcReset();
      repeat (6) @(negedge funcClk);
      base = cntDeliv;
      eventVec = 16'h1111;
      @(posedge funcClk); #1; clkEnIn = 0;
      @(negedge funcClk); eventVec = 16'h0000; p0 = pulseAll;
      repeat (8) @(negedge funcClk);
      chk("R12 stamp held", cycleCount, base + 1);
      chk("R12 no pulses", pulseAll, p0);
      @(posedge funcClk); #1; clkEnIn = 1;
      @(negedge funcClk); eventVec = 16'h2222;
      @(negedge funcClk); eventVec = 16'h3333;
      @(negedge funcClk); eventVec = 16'h0000;
      repeat (20) @(negedge funcClk);
      chk("R12 matcher kept stage", cycleCount, base + 3);
      @(negedge tck); #2;
      chk("R12 halt after resume of enable", {31'd0, haltSeen}, 1);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog R4 actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

endmodule